// File: doc/BRIEF.md
# HDLC Transmit Block-FIFO Controller

This block sits between a host and a byte-serial HDLC framer. Its transmit storage is two equal blocks, each `BLK_BYTES` bytes deep (32 by default). The host fills the current block one byte at a time. It then hands the block over with a send command. A flag on that command says whether the block closes the frame. Committed blocks are drained in the order they were handed over, through a valid/ready byte port that marks the final byte of each frame.

A pool-ready interrupt tells the host when it may fill another block. The interrupt fires in two cases:
- the host hands over a block while the other block is already empty;
- the last byte of a block leaves through the downstream port.

A long frame therefore travels as several full blocks and a short closing block. A 76-byte frame, for example, goes out as 32 + 32 + 12 bytes. The downstream stream runs on from one committed block to the next without a gap.

Sticky status bits report three things: pool-ready events, host misuse (a rejected write or command) and underrun. Underrun means the framer was ready while a frame was open and no data was committed. A single host read strobe clears all three bits.

Top module: `hdlc_txq_ctrl`

## Requirements
- R1: After reset, `out_valid`, `irq_pool`, `stat_pool`, `stat_err` and `stat_underrun` are all 0.
- R2: A host write is stored only if the block being filled is not committed and holds fewer than `BLK_BYTES` bytes. Any other write is ignored and sets `stat_err` one cycle later.
- R3: A send command (`host_send`=1) is accepted only if the block being filled is not committed and holds at least one byte. An accepted command commits that block with its byte count. Committed blocks are sent in commit order, and the bytes of each block are sent in write order.
- R4: When a send command is accepted and the other block is uncommitted, `irq_pool` is 1 in the cycle after the accepting edge.
- R5: The handshake of the last byte of a block releases that block, and `irq_pool` is 1 in the next cycle. If another block is committed, its first byte is valid in the very next cycle, with no idle cycle.
- R6: `out_eof` is 1 only with the last byte of a block committed with `host_send_eom`=1. It is 0 for every other byte.
- R7: A send command that is not accepted (the block being filled is committed, or it is empty) commits nothing, raises no interrupt, and sets `stat_err`.
- R8: While `out_valid`=1 and `out_ready`=0, the outputs `out_valid`, `out_data` and `out_eof` keep their values into the next cycle.
- R9: `irq_pool` is a pulse that sets `stat_pool` on the following edge. A one-cycle `host_stat_rd` clears `stat_pool`, `stat_err` and `stat_underrun`. A set event in the same cycle wins over the clear.
- R10: When `out_ready`=1 and `out_valid`=0 while a frame is open, `stat_underrun` is set. A frame is open after an accepted send with `host_send_eom`=0, and stays open until an accepted send with `host_send_eom`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host byte write strobe |
| host_wr_data | input | DATA_W | Host write byte |
| host_send | input | 1 | Commit the block being filled |
| host_send_eom | input | 1 | With `host_send`: the block closes the frame |
| host_stat_rd | input | 1 | Status read strobe; clears the sticky bits |
| out_valid | output | 1 | Downstream byte valid |
| out_data | output | DATA_W | Downstream byte |
| out_eof | output | 1 | Last byte of the frame |
| out_ready | input | 1 | Downstream accepts the byte |
| irq_pool | output | 1 | One-cycle pool-ready interrupt |
| stat_pool | output | 1 | Sticky pool-ready status |
| stat_err | output | 1 | Sticky host-misuse status |
| stat_underrun | output | 1 | Sticky underrun status |

## Verification
The bench uses the default parameters: two blocks of 32 bytes with 8-bit data. With these values a 76-byte frame crosses both blocks and wraps back to the first one. The host side stalls on a full pool while the framer holds `out_ready` low. A 33rd write lands exactly on the block limit. The same setting also reaches the two zero-gap cases: a block-to-block hand-off during streaming, and an underrun from a short open block.

// File: rtl/hdlc_txq_pkg.sv
package hdlc_txq_pkg;

  // Index of the block that follows idx in the circular block order.
  function automatic int blk_after(input int idx, input int nblk);
    return (idx + 1 >= nblk) ? 0 : idx + 1;
  endfunction

  // True when position pos is the final byte of a block holding len bytes.
  function automatic logic is_final_byte(input int pos, input int len);
    return (len != 0) && (pos + 1 == len);
  endfunction

  // Whether a block holding cnt bytes can take one more byte.
  function automatic logic has_room(input int cnt, input int cap);
    return cnt < cap;
  endfunction

endpackage

// File: rtl/hdlc_txq_store.sv
module hdlc_txq_store #(
  parameter int NB  = 2,
  parameter int BB  = 32,
  parameter int DW  = 8,
  parameter int BIW = 1,
  parameter int IW  = 5
) (
  input  logic           clk,
  input  logic           wr_en,
  input  logic [BIW-1:0] wr_blk,
  input  logic [IW-1:0]  wr_pos,
  input  logic [DW-1:0]  wr_data,
  input  logic [BIW-1:0] rd_blk,
  input  logic [IW-1:0]  rd_pos,
  output logic [DW-1:0]  rd_data
);

  logic [DW-1:0] rd_word [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [DW-1:0] mem [BB];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_blk == BIW'(b))) mem[wr_pos] <= wr_data;
    end

    assign rd_word[b] = mem[rd_pos];
  end

  assign rd_data = rd_word[rd_blk];

endmodule

// File: rtl/hdlc_txq_fill.sv
module hdlc_txq_fill
  import hdlc_txq_pkg::*;
#(
  parameter int NB  = 2,
  parameter int BB  = 32,
  parameter int BIW = 1,
  parameter int IW  = 5,
  parameter int CW  = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   send,
  input  logic                   send_eom,
  input  logic                   rel_evt,
  input  logic [BIW-1:0]         rel_blk,
  output logic                   st_wr_en,
  output logic [BIW-1:0]         st_wr_blk,
  output logic [IW-1:0]          st_wr_pos,
  output logic [NB-1:0]          committed,
  output logic [NB-1:0][CW-1:0]  blk_len,
  output logic [NB-1:0]          blk_eom,
  output logic                   frame_open,
  output logic                   wr_rej,
  output logic                   cmd_acc,
  output logic                   cmd_rej,
  output logic                   next_free
);

  logic [BIW-1:0] fill_blk;
  logic [CW-1:0]  fill_cnt;
  logic [BIW-1:0] nxt_blk;
  logic [CW-1:0]  cnt_now;
  logic           fill_free;
  logic           wr_ok;
  logic [NB-1:0]  committed_nx;

  assign fill_free = !committed[fill_blk];
  assign wr_ok     = wr_en && fill_free && has_room(int'(fill_cnt), BB);
  assign wr_rej    = wr_en && !wr_ok;
  assign cnt_now   = fill_cnt + CW'(wr_ok);
  assign cmd_acc   = send && fill_free && (cnt_now != '0);
  assign cmd_rej   = send && !cmd_acc;
  assign nxt_blk   = BIW'(blk_after(int'(fill_blk), NB));
  assign next_free = !committed[nxt_blk];

  assign st_wr_en  = wr_ok;
  assign st_wr_blk = fill_blk;
  assign st_wr_pos = IW'(fill_cnt);

  always_comb begin
    committed_nx = committed;
    for (int b = 0; b < NB; b++) begin
      if (cmd_acc && (fill_blk == BIW'(b)))      committed_nx[b] = 1'b1;
      else if (rel_evt && (rel_blk == BIW'(b)))  committed_nx[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      committed  <= '0;
      blk_len    <= '0;
      blk_eom    <= '0;
      fill_blk   <= '0;
      fill_cnt   <= '0;
      frame_open <= 1'b0;
    end else begin
      committed <= committed_nx;
      if (cmd_acc) begin
        blk_len[fill_blk] <= cnt_now;
        blk_eom[fill_blk] <= send_eom;
        fill_blk          <= nxt_blk;
        fill_cnt          <= '0;
        frame_open        <= !send_eom;
      end else if (wr_ok) begin
        fill_cnt <= cnt_now;
      end
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CW'(BB));

  a_r7_rej_keeps_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rej && !wr_ok) |=> $stable(fill_cnt) && $stable(fill_blk));

endmodule

// File: rtl/hdlc_txq_drain.sv
module hdlc_txq_drain
  import hdlc_txq_pkg::*;
#(
  parameter int NB  = 2,
  parameter int BIW = 1,
  parameter int IW  = 5,
  parameter int CW  = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NB-1:0]          committed,
  input  logic [NB-1:0][CW-1:0]  blk_len,
  input  logic [NB-1:0]          blk_eom,
  input  logic                   out_ready,
  output logic                   out_valid,
  output logic                   out_eof,
  output logic [BIW-1:0]         rd_blk,
  output logic [IW-1:0]          rd_pos,
  output logic                   rel_evt,
  output logic [BIW-1:0]         rel_blk
);

  logic [BIW-1:0] drain_blk;
  logic           at_end;
  logic           hs;

  assign out_valid = committed[drain_blk];
  assign at_end    = is_final_byte(int'(rd_pos), int'(blk_len[drain_blk]));
  assign hs        = out_valid && out_ready;
  assign rel_evt   = hs && at_end;
  assign rel_blk   = drain_blk;
  assign out_eof   = out_valid && at_end && blk_eom[drain_blk];
  assign rd_blk    = drain_blk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drain_blk <= '0;
      rd_pos    <= '0;
    end else if (hs) begin
      if (at_end) begin
        drain_blk <= BIW'(blk_after(int'(drain_blk), NB));
        rd_pos    <= '0;
      end else begin
        rd_pos <= rd_pos + IW'(1);
      end
    end
  end

  a_r3_pos_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (CW'(rd_pos) < blk_len[drain_blk]));

endmodule

// File: rtl/hdlc_txq_status.sv
module hdlc_txq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_src,
  input  logic err_src,
  input  logic udr_src,
  input  logic stat_rd,
  output logic irq_pool,
  output logic stat_pool,
  output logic stat_err,
  output logic stat_udr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pool  <= 1'b0;
      stat_pool <= 1'b0;
      stat_err  <= 1'b0;
      stat_udr  <= 1'b0;
    end else begin
      irq_pool  <= irq_src;
      stat_pool <= irq_pool | (stat_pool & !stat_rd);
      stat_err  <= err_src  | (stat_err  & !stat_rd);
      stat_udr  <= udr_src  | (stat_udr  & !stat_rd);
    end
  end

  a_r9_irq_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pool |=> stat_pool);

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !irq_pool && !err_src && !udr_src) |=> !stat_pool && !stat_err && !stat_udr);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_src |=> stat_err);

  a_r10_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    udr_src |=> stat_udr);

endmodule

// File: rtl/hdlc_txq_ctrl.sv
module hdlc_txq_ctrl #(
  parameter int BLK_BYTES = 32,
  parameter int NUM_BLKS  = 2,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [DATA_W-1:0] host_wr_data,
  input  logic              host_send,
  input  logic              host_send_eom,
  input  logic              host_stat_rd,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_eof,
  input  logic              out_ready,
  output logic              irq_pool,
  output logic              stat_pool,
  output logic              stat_err,
  output logic              stat_underrun
);

  localparam int BIW = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1;
  localparam int IW  = (BLK_BYTES > 1) ? $clog2(BLK_BYTES) : 1;
  localparam int CW  = $clog2(BLK_BYTES + 1);

  // Internal events, named for the assertions.
  logic                      st_wr_en;
  logic [BIW-1:0]            st_wr_blk;
  logic [IW-1:0]             st_wr_pos;
  logic [NUM_BLKS-1:0]       committed;
  logic [NUM_BLKS-1:0][CW-1:0] blk_len;
  logic [NUM_BLKS-1:0]       blk_eom;
  logic                      frame_open;
  logic                      wr_rej;
  logic                      cmd_acc;
  logic                      cmd_rej;
  logic                      next_free;
  logic [BIW-1:0]            rd_blk;
  logic [IW-1:0]             rd_pos;
  logic                      rel_evt;
  logic [BIW-1:0]            rel_blk;
  logic                      irq_src;
  logic                      err_evt;
  logic                      udr_evt;

  hdlc_txq_fill #(.NB(NUM_BLKS), .BB(BLK_BYTES), .BIW(BIW), .IW(IW), .CW(CW)) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (host_wr_en),
    .send       (host_send),
    .send_eom   (host_send_eom),
    .rel_evt    (rel_evt),
    .rel_blk    (rel_blk),
    .st_wr_en   (st_wr_en),
    .st_wr_blk  (st_wr_blk),
    .st_wr_pos  (st_wr_pos),
    .committed  (committed),
    .blk_len    (blk_len),
    .blk_eom    (blk_eom),
    .frame_open (frame_open),
    .wr_rej     (wr_rej),
    .cmd_acc    (cmd_acc),
    .cmd_rej    (cmd_rej),
    .next_free  (next_free)
  );

  hdlc_txq_store #(.NB(NUM_BLKS), .BB(BLK_BYTES), .DW(DATA_W), .BIW(BIW), .IW(IW)) u_store (
    .clk     (clk),
    .wr_en   (st_wr_en),
    .wr_blk  (st_wr_blk),
    .wr_pos  (st_wr_pos),
    .wr_data (host_wr_data),
    .rd_blk  (rd_blk),
    .rd_pos  (rd_pos),
    .rd_data (out_data)
  );

  hdlc_txq_drain #(.NB(NUM_BLKS), .BIW(BIW), .IW(IW), .CW(CW)) u_drain (
    .clk       (clk),
    .rst_n     (rst_n),
    .committed (committed),
    .blk_len   (blk_len),
    .blk_eom   (blk_eom),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_eof   (out_eof),
    .rd_blk    (rd_blk),
    .rd_pos    (rd_pos),
    .rel_evt   (rel_evt),
    .rel_blk   (rel_blk)
  );

  assign irq_src = rel_evt | (cmd_acc & next_free);
  assign err_evt = wr_rej | cmd_rej;
  assign udr_evt = out_ready & !out_valid & frame_open;

  hdlc_txq_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_src   (irq_src),
    .err_src   (err_evt),
    .udr_src   (udr_evt),
    .stat_rd   (host_stat_rd),
    .irq_pool  (irq_pool),
    .stat_pool (stat_pool),
    .stat_err  (stat_err),
    .stat_udr  (stat_underrun)
  );

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_eof));

  a_r5_release_irq: assert property (@(posedge clk) disable iff (!rst_n)
    rel_evt |=> irq_pool);

  a_r4_accept_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc && next_free) |=> irq_pool);

  a_r6_eof_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_valid);

  a_r7_rej_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rej && !rel_evt) |=> !irq_pool);

endmodule

// File: tb/hdlc_txq_ctrl_bench.sv
`timescale 1ns/1ps
module hdlc_txq_ctrl_bench;

  localparam int BB = 32;
  localparam int NB = 2;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr_en = 1'b0;
  logic [DW-1:0] host_wr_data = '0;
  logic host_send = 1'b0;
  logic host_send_eom = 1'b0;
  logic host_stat_rd = 1'b0;
  logic out_ready = 1'b0;
  logic out_valid, out_eof, irq_pool, stat_pool, stat_err, stat_underrun;
  logic [DW-1:0] out_data;

  int n_tests = 0;
  int n_fail  = 0;
  int irq_cnt = 0;
  logic [DW-1:0] rx_q [$];
  bit            eof_q [$];

  always #2.5 clk = ~clk;

  hdlc_txq_ctrl #(.BLK_BYTES(BB), .NUM_BLKS(NB), .DATA_W(DW)) u_hdlc_txq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .host_send(host_send), .host_send_eom(host_send_eom),
    .host_stat_rd(host_stat_rd),
    .out_valid(out_valid), .out_data(out_data), .out_eof(out_eof),
    .out_ready(out_ready), .irq_pool(irq_pool), .stat_pool(stat_pool),
    .stat_err(stat_err), .stat_underrun(stat_underrun)
  );

  // Mid-cycle monitor: values seen here are the ones the next rising edge uses.
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        rx_q.push_back(out_data);
        eof_q.push_back(out_eof);
      end
      if (irq_pool) irq_cnt++;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic host_write(input logic [DW-1:0] v);
    host_wr_en = 1'b1;
    host_wr_data = v;
    tick();
    host_wr_en = 1'b0;
  endtask

  task automatic host_cmd(input bit eom);
    host_send = 1'b1;
    host_send_eom = eom;
    tick();
    host_send = 1'b0;
    host_send_eom = 1'b0;
  endtask

  task automatic status_read();
    host_stat_rd = 1'b1;
    tick();
    host_stat_rd = 1'b0;
  endtask

  task automatic fresh();
    status_read();
    rx_q.delete();
    eof_q.delete();
    irq_cnt = 0;
  endtask

  task automatic wait_irq();
    int guard = 0;
    while (!irq_pool && guard < 500) begin
      tick();
      guard++;
    end
  endtask

  // Compare the received stream with base+i and a single eof on the last byte.
  task automatic check_stream(input string req, input int base, input int n);
    int bad_data = 0;
    int bad_eof = 0;
    check_eq(req, "byte count", rx_q.size(), n);
    for (int i = 0; i < rx_q.size() && i < n; i++) begin
      if (rx_q[i] != DW'(base + i)) bad_data++;
      if (eof_q[i] != (i == n - 1)) bad_eof++;
    end
    check_eq(req, "data mismatches", bad_data, 0);
    check_eq("R6", "eof misplacements", bad_eof, 0);
  endtask

  task automatic t_reset();
    check_eq("R1", "out_valid", int'(out_valid), 0);
    check_eq("R1", "irq_pool", int'(irq_pool), 0);
    check_eq("R1", "stat_pool", int'(stat_pool), 0);
    check_eq("R1", "stat_err", int'(stat_err), 0);
    check_eq("R1", "stat_underrun", int'(stat_underrun), 0);
  endtask

  task automatic t_short_frame();
    fresh();
    out_ready = 1'b1;
    for (int i = 0; i < 12; i++) host_write(DW'(8'h40 + i));
    host_cmd(1'b1);
    check_eq("R4", "immediate irq", int'(irq_pool), 1);
    tick();
    check_eq("R9", "stat_pool set", int'(stat_pool), 1);
    repeat (20) tick();
    check_stream("R3", 8'h40, 12);
    check_eq("R5", "irq count short frame", irq_cnt, 2);
    check_eq("R10", "no underrun", int'(stat_underrun), 0);
    status_read();
    check_eq("R9", "read clears pool", int'(stat_pool), 0);
  endtask

  task automatic t_long_frame();
    fresh();
    out_ready = 1'b0;
    for (int i = 0; i < 32; i++) host_write(DW'(8'h10 + i));
    host_cmd(1'b0);
    for (int i = 32; i < 64; i++) host_write(DW'(8'h10 + i));
    host_cmd(1'b0);
    repeat (3) tick();
    check_eq("R4", "no irq when pool full", irq_cnt, 1);
    out_ready = 1'b1;
    wait_irq();
    for (int i = 64; i < 76; i++) host_write(DW'(8'h10 + i));
    host_cmd(1'b1);
    repeat (80) tick();
    check_stream("R3", 8'h10, 76);
    check_eq("R5", "irq count 76-byte frame", irq_cnt, 4);
    check_eq("R5", "no gap between blocks", int'(stat_underrun), 0);
  endtask

  task automatic t_overflow();
    fresh();
    out_ready = 1'b0;
    for (int i = 0; i < 33; i++) host_write(DW'(8'h80 + i));
    check_eq("R2", "err after 33rd write", int'(stat_err), 1);
    host_cmd(1'b1);
    out_ready = 1'b1;
    repeat (40) tick();
    check_stream("R2", 8'h80, 32);
  endtask

  task automatic t_pool_full();
    logic [DW-1:0] d0;
    logic          e0;
    fresh();
    out_ready = 1'b0;
    for (int i = 0; i < 4; i++) host_write(DW'(8'hC0 + i));
    host_cmd(1'b0);
    for (int i = 4; i < 8; i++) host_write(DW'(8'hC0 + i));
    host_cmd(1'b1);
    check_eq("R2", "err before bad write", int'(stat_err), 0);
    host_write(8'hEE);
    check_eq("R2", "err after write into full pool", int'(stat_err), 1);
    status_read();
    host_cmd(1'b1);
    check_eq("R7", "err after cmd into full pool", int'(stat_err), 1);
    repeat (2) tick();
    check_eq("R7", "no irq for rejected cmd", irq_cnt, 1);
    d0 = out_data;
    e0 = out_eof;
    repeat (3) tick();
    check_eq("R8", "valid held", int'(out_valid), 1);
    check_eq("R8", "data held", int'(out_data), int'(d0));
    check_eq("R8", "eof held", int'(out_eof), int'(e0));
    check_eq("R8", "no transfer while not ready", rx_q.size(), 0);
    out_ready = 1'b1;
    repeat (15) tick();
    check_stream("R3", 8'hC0, 8);
    check_eq("R5", "irq count after drain", irq_cnt, 3);
  endtask

  task automatic t_empty_cmd();
    fresh();
    out_ready = 1'b1;
    host_cmd(1'b1);
    repeat (3) tick();
    check_eq("R7", "err on empty cmd", int'(stat_err), 1);
    check_eq("R7", "no irq on empty cmd", irq_cnt, 0);
    check_eq("R7", "nothing sent", rx_q.size(), 0);
  endtask

  task automatic t_underrun();
    fresh();
    out_ready = 1'b1;
    for (int i = 0; i < 3; i++) host_write(DW'(8'h20 + i));
    host_cmd(1'b0);
    repeat (8) tick();
    check_eq("R10", "underrun set", int'(stat_underrun), 1);
    for (int i = 3; i < 5; i++) host_write(DW'(8'h20 + i));
    host_cmd(1'b1);
    repeat (8) tick();
    check_stream("R3", 8'h20, 5);
    status_read();
    check_eq("R9", "read clears underrun", int'(stat_underrun), 0);
    repeat (4) tick();
    check_eq("R10", "no underrun once frame closed", int'(stat_underrun), 0);
  endtask

  initial begin
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_short_frame();
    t_long_frame();
    t_overflow();
    t_pool_full();
    t_empty_cmd();
    t_underrun();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule